// File: doc/BRIEF.md
# Multi-Mode Video Sample Demultiplexer

The block sits between a pixel source and three downstream converter channels. It takes three 8-bit input ports and drives one aligned sample per channel, each with its own valid strobe. A 2-bit mode input selects the format. The two full-rate formats capture all three ports on every clock. The two subsampled 4:2:2 formats rebuild separate luma and chroma streams from interleaved data. One of them uses two ports and the other uses a single port.

The active-low blanking input has two jobs. While it is low, every output is forced to a blanking code and the mode input is latched. When it returns high, the sample sequence restarts from a known phase. The luma blanking code is always zero. The chroma blanking code depends on the sync-insertion select and the variant select. All outputs are registered, so they appear one clock after the edge that captures them.

Top module: `vid_demux`

## Requirements
- R1: While rst_ni is low, all data outputs are 0 and vld_o is 3'b000, and this takes effect without waiting for a clock edge.
- R2: In modes 2'b00 and 2'b01, each non-blanking edge loads ch0_o from pix_a_i, ch1_o from pix_b_i and ch2_o from pix_c_i, and sets vld_o to 3'b111. Bit 0 of vld_o is channel 0 (luma/G), bit 1 is channel 1 (Pb/B) and bit 2 is channel 2 (Pr/R).
- R3: In mode 2'b10, ch0_o loads pix_a_i on every non-blanking edge. pix_c_i carries Pb on even phases and Pr on odd phases. On an odd phase, ch1_o takes the stored Pb and ch2_o takes the current Pr, with vld_o = 3'b111. On an even phase, vld_o = 3'b001. pix_b_i is ignored.
- R4: In mode 2'b11, only pix_a_i is used, and it carries the repeating order Pb, Y, Pr, Y over phases 0 to 3. Phase 1 loads ch0_o with vld_o = 3'b001. Phase 3 loads ch0_o and both chroma outputs together with vld_o = 3'b111. Phases 0 and 2 give vld_o = 3'b000.
- R5: The first non-blanking edge after blank_ni rises is phase 0. In both 4:2:2 modes, that edge's sample is taken as Pb.
- R6: On every edge where blank_ni is low, ch0_o becomes 0 and vld_o becomes 3'b000.
- R7: On a blanking edge, ch1_o and ch2_o become 128 if alt_var_i is 1. If alt_var_i is 0, they become 128 when sync_all_i is 1 and 0 when sync_all_i is 0.
- R8: mode_i is latched only on blanking edges. A change while blank_ni is high has no effect.
- R9: A channel whose vld_o bit is low after a non-blanking edge holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Format select: 00 GBR 4:4:4, 01 YPbPr 4:4:4, 10 4:2:2 two-port, 11 4:2:2 one-port |
| blank_ni | input | 1 | Blanking, active low |
| sync_all_i | input | 1 | 1 = sync inserted on all three channels |
| alt_var_i | input | 1 | 1 = chroma blanking code fixed at mid-scale |
| pix_a_i | input | 8 | G / Y port, and the multiplexed port in one-port mode |
| pix_b_i | input | 8 | B / Pb port |
| pix_c_i | input | 8 | R / Pr port, and the chroma port in two-port mode |
| ch0_o | output | 8 | Luma / G sample |
| ch1_o | output | 8 | Pb / B sample |
| ch2_o | output | 8 | Pr / R sample |
| vld_o | output | 3 | Per-channel update strobes |

## Verification
The hardest case to reach is a blanking pulse that arrives mid-group in one-port mode. It leaves a stale Pb in the hold register, and the restarted sequence must overwrite it before the next chroma output. The stimulus table stops the one-port stream just after a new Pb has been captured. It then pulses blanking and checks that the next complete group carries only the post-restart Pb and Pr values. The same table changes mode_i in the middle of an active run to show that the change is ignored.

// File: rtl/vid_demux_pkg.sv
package vid_demux_pkg;
  typedef enum logic [1:0] {
    MODE_GBR444   = 2'd0,
    MODE_YC444    = 2'd1,
    MODE_YC422_2P = 2'd2,
    MODE_YC422_1P = 2'd3
  } vid_mode_e;

  localparam int unsigned PHASES = 4;
  localparam int unsigned PH_W   = $clog2(PHASES);
endpackage

// File: rtl/vid_blank_code.sv
module vid_blank_code #(
  parameter int unsigned DW = 8
) (
  input  logic          sync_all_i,
  input  logic          alt_var_i,
  output logic [DW-1:0] luma_o,
  output logic [DW-1:0] chroma_o
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

  assign luma_o   = '0;
  assign chroma_o = (alt_var_i || sync_all_i) ? MID : '0;
endmodule

// File: rtl/vid_phase_ctr.sv
module vid_phase_ctr
  import vid_demux_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  output logic [PH_W-1:0] ph_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ph_o <= '0;
    else if (clr_i) ph_o <= '0;
    else            ph_o <= ph_o + 1'b1;
  end
endmodule

// File: rtl/vid_sample_route.sv
module vid_sample_route
  import vid_demux_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  vid_mode_e       mode_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic [DW-1:0]   pix_a_i,
  input  logic [DW-1:0]   pix_b_i,
  input  logic [DW-1:0]   pix_c_i,
  input  logic [DW-1:0]   pb_q_i,
  input  logic [DW-1:0]   pr_q_i,
  output logic [2:0]      ld_o,
  output logic [DW-1:0]   d0_o,
  output logic [DW-1:0]   d1_o,
  output logic [DW-1:0]   d2_o,
  output logic            cap_pb_o,
  output logic            cap_pr_o,
  output logic [DW-1:0]   cap_d_o
);
  always_comb begin
    ld_o     = 3'b000;
    d0_o     = pix_a_i;
    d1_o     = pb_q_i;
    d2_o     = pr_q_i;
    cap_pb_o = 1'b0;
    cap_pr_o = 1'b0;
    cap_d_o  = pix_a_i;
    unique case (mode_i)
      MODE_GBR444, MODE_YC444: begin
        ld_o = 3'b111;
        d1_o = pix_b_i;
        d2_o = pix_c_i;
      end
      MODE_YC422_2P: begin
        cap_d_o = pix_c_i;
        if (!ph_i[0]) begin
          ld_o     = 3'b001;
          cap_pb_o = 1'b1;
        end else begin
          ld_o = 3'b111;
          d2_o = pix_c_i;   // Pr arrives with its completing luma
        end
      end
      MODE_YC422_1P: begin
        unique case (ph_i)
          2'd0: cap_pb_o = 1'b1;
          2'd1: ld_o     = 3'b001;
          2'd2: cap_pr_o = 1'b1;
          default: ld_o  = 3'b111;
        endcase
      end
      default: ld_o = 3'b000;
    endcase
  end
endmodule

// File: rtl/vid_demux.sv
module vid_demux
  import vid_demux_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    mode_i,
  input  logic          blank_ni,
  input  logic          sync_all_i,
  input  logic          alt_var_i,
  input  logic [DW-1:0] pix_a_i,
  input  logic [DW-1:0] pix_b_i,
  input  logic [DW-1:0] pix_c_i,
  output logic [DW-1:0] ch0_o,
  output logic [DW-1:0] ch1_o,
  output logic [DW-1:0] ch2_o,
  output logic [2:0]    vld_o
);
  vid_mode_e       mode_q;
  logic [PH_W-1:0] ph;
  logic [DW-1:0]   pb_q, pr_q;
  logic [DW-1:0]   bl_luma, bl_chroma;
  logic [2:0]      ld;
  logic [DW-1:0]   d0, d1, d2, cap_d;
  logic            cap_pb, cap_pr;

  vid_phase_ctr u_ph (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!blank_ni),
    .ph_o  (ph)
  );

  vid_blank_code #(.DW(DW)) u_bl (
    .sync_all_i(sync_all_i),
    .alt_var_i (alt_var_i),
    .luma_o    (bl_luma),
    .chroma_o  (bl_chroma)
  );

  vid_sample_route #(.DW(DW)) u_rt (
    .mode_i  (mode_q),
    .ph_i    (ph),
    .pix_a_i (pix_a_i),
    .pix_b_i (pix_b_i),
    .pix_c_i (pix_c_i),
    .pb_q_i  (pb_q),
    .pr_q_i  (pr_q),
    .ld_o    (ld),
    .d0_o    (d0),
    .d1_o    (d1),
    .d2_o    (d2),
    .cap_pb_o(cap_pb),
    .cap_pr_o(cap_pr),
    .cap_d_o (cap_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_GBR444;
      pb_q   <= '0;
      pr_q   <= '0;
      ch0_o  <= '0;
      ch1_o  <= '0;
      ch2_o  <= '0;
      vld_o  <= '0;
    end else if (!blank_ni) begin
      mode_q <= vid_mode_e'(mode_i);
      ch0_o  <= bl_luma;
      ch1_o  <= bl_chroma;
      ch2_o  <= bl_chroma;
      vld_o  <= '0;
    end else begin
      if (cap_pb) pb_q  <= cap_d;
      if (cap_pr) pr_q  <= cap_d;
      if (ld[0])  ch0_o <= d0;
      if (ld[1])  ch1_o <= d1;
      if (ld[2])  ch2_o <= d2;
      vld_o <= ld;
    end
  end
endmodule

// File: rtl/vid_demux_chk.sv
module vid_demux_chk #(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          blank_ni,
  input logic          sync_all_i,
  input logic          alt_var_i,
  input logic [DW-1:0] ch0_o,
  input logic [DW-1:0] ch1_o,
  input logic [DW-1:0] ch2_o,
  input logic [2:0]    vld_o,
  input logic [1:0]    mode_q_i,
  input logic [1:0]    ph_i
);
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

  p_blank_luma_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blank_ni |=> (ch0_o == '0 && vld_o == 3'b000));

  p_chroma_alt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_ni && alt_var_i) |=> (ch1_o == MID && ch2_o == MID));

  p_chroma_y_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!blank_ni && !alt_var_i && !sync_all_i) |=> (ch1_o == '0 && ch2_o == '0));

  p_chroma_pair_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o[1] |-> (vld_o[2] && vld_o[0]));

  p_mode_lock_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blank_ni && $past(blank_ni)) |-> $stable(mode_q_i));

  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(blank_ni) |-> (ph_i == 2'd0));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(blank_ni) && !vld_o[1]) |-> $stable(ch1_o));
endmodule

bind vid_demux vid_demux_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .blank_ni  (blank_ni),
  .sync_all_i(sync_all_i),
  .alt_var_i (alt_var_i),
  .ch0_o     (ch0_o),
  .ch1_o     (ch1_o),
  .ch2_o     (ch2_o),
  .vld_o     (vld_o),
  .mode_q_i  (mode_q),
  .ph_i      (ph)
);

// File: tb/tb_vid_demux.sv
module tb_vid_demux;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'd0;
  logic       blank_ni = 1'b0;
  logic       sync_all_i = 1'b0;
  logic       alt_var_i = 1'b0;
  logic [7:0] pix_a_i = '0, pix_b_i = '0, pix_c_i = '0;
  logic [7:0] ch0_o, ch1_o, ch2_o;
  logic [2:0] vld_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  vid_demux dut (.*);

  // {blank_n, mode, sync_all, alt, a, b, c, exp0, exp1, exp2, exp_vld, req}
  localparam int N = 21;
  localparam logic [59:0] TBL [N] = '{
    {1'b0,2'd0,1'b1,1'b0,8'd11,8'd12,8'd13,8'd0, 8'd128,8'd128,3'b000,4'd7}, // R7 code with sync on all
    {1'b1,2'd0,1'b1,1'b0,8'd21,8'd22,8'd23,8'd21,8'd22, 8'd23, 3'b111,4'd2}, // R2
    {1'b1,2'd1,1'b1,1'b0,8'd31,8'd32,8'd33,8'd31,8'd32, 8'd33, 3'b111,4'd8}, // R8
    {1'b0,2'd2,1'b0,1'b0,8'd1, 8'd2, 8'd3, 8'd0, 8'd0,  8'd0,  3'b000,4'd7}, // R7 luma-only sync
    {1'b1,2'd2,1'b0,1'b0,8'd40,8'd99,8'd41,8'd40,8'd0,  8'd0,  3'b001,4'd3}, // R3 Pb
    {1'b1,2'd2,1'b0,1'b0,8'd42,8'd99,8'd43,8'd42,8'd41, 8'd43, 3'b111,4'd3}, // R3 Pr
    {1'b1,2'd2,1'b0,1'b0,8'd44,8'd99,8'd45,8'd44,8'd41, 8'd43, 3'b001,4'd9}, // R9
    {1'b1,2'd3,1'b0,1'b0,8'd46,8'd99,8'd47,8'd46,8'd45, 8'd47, 3'b111,4'd8}, // R8
    {1'b0,2'd3,1'b0,1'b1,8'd5, 8'd6, 8'd7, 8'd0, 8'd128,8'd128,3'b000,4'd7}, // R7 alt variant
    {1'b1,2'd3,1'b0,1'b1,8'd50,8'hEE,8'hEE,8'd0, 8'd128,8'd128,3'b000,4'd4}, // R4 Pb
    {1'b1,2'd3,1'b0,1'b1,8'd51,8'hEE,8'hEE,8'd51,8'd128,8'd128,3'b001,4'd4}, // R4 Y0
    {1'b1,2'd3,1'b0,1'b1,8'd52,8'hEE,8'hEE,8'd51,8'd128,8'd128,3'b000,4'd9}, // R9 Pr
    {1'b1,2'd3,1'b0,1'b1,8'd53,8'hEE,8'hEE,8'd53,8'd50, 8'd52, 3'b111,4'd4}, // R4 Y1
    {1'b1,2'd3,1'b0,1'b1,8'd54,8'hEE,8'hEE,8'd53,8'd50, 8'd52, 3'b000,4'd4}, // R4 stale Pb
    {1'b0,2'd3,1'b1,1'b1,8'd9, 8'd9, 8'd9, 8'd0, 8'd128,8'd128,3'b000,4'd7}, // R7 alt + all
    {1'b1,2'd3,1'b1,1'b1,8'd60,8'hEE,8'hEE,8'd0, 8'd128,8'd128,3'b000,4'd5}, // R5
    {1'b1,2'd3,1'b1,1'b1,8'd61,8'hEE,8'hEE,8'd61,8'd128,8'd128,3'b001,4'd5}, // R5
    {1'b1,2'd3,1'b1,1'b1,8'd62,8'hEE,8'hEE,8'd61,8'd128,8'd128,3'b000,4'd5}, // R5
    {1'b1,2'd3,1'b1,1'b1,8'd63,8'hEE,8'hEE,8'd63,8'd60, 8'd62, 3'b111,4'd5}, // R5
    {1'b0,2'd1,1'b0,1'b0,8'd8, 8'd8, 8'd8, 8'd0, 8'd0,  8'd0,  3'b000,4'd6}, // R6
    {1'b1,2'd1,1'b0,1'b0,8'd70,8'd71,8'd72,8'd70,8'd71, 8'd72, 3'b111,4'd2}  // R2
  };

  task automatic check(input int req, input logic [7:0] e0, e1, e2, input logic [2:0] ev);
    total++;
    if (ch0_o !== e0 || ch1_o !== e1 || ch2_o !== e2 || vld_o !== ev) begin
      bad++;
      $display("FAIL R%0d: got %0d %0d %0d vld=%b expected %0d %0d %0d vld=%b",
               req, ch0_o, ch1_o, ch2_o, vld_o, e0, e1, e2, ev);
    end
  endtask

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #12;
    check(1, 8'd0, 8'd0, 8'd0, 3'b000); // R1 reset state
    @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < N; i++) begin
      {blank_ni, mode_i, sync_all_i, alt_var_i, pix_a_i, pix_b_i, pix_c_i} = TBL[i][59:31];
      @(posedge clk_i);
      @(negedge clk_i);
      check(int'(TBL[i][3:0]), TBL[i][30:23], TBL[i][22:15], TBL[i][14:7], TBL[i][6:4]);
    end
    // R1: asynchronous reset mid-run
    #2 rst_ni = 1'b0;
    #1 check(1, 8'd0, 8'd0, 8'd0, 3'b000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R3: restart in two-port mode after blanking, b port ignored
    blank_ni = 1'b0; mode_i = 2'd2; sync_all_i = 1'b1; alt_var_i = 1'b0;
    @(posedge clk_i); @(negedge clk_i);
    check(7, 8'd0, 8'd128, 8'd128, 3'b000);
    blank_ni = 1'b1; pix_a_i = 8'd80; pix_b_i = 8'd1; pix_c_i = 8'd81;
    @(posedge clk_i); @(negedge clk_i);
    check(5, 8'd80, 8'd128, 8'd128, 3'b001);
    pix_a_i = 8'd82; pix_b_i = 8'd2; pix_c_i = 8'd83;
    @(posedge clk_i); @(negedge clk_i);
    check(3, 8'd82, 8'd81, 8'd83, 3'b111);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule